// File: doc/BRIEF.md
# Transfer Descriptor Buffer Address Walker

This block steps through the transfer descriptors kept in one region of an on-chip buffer memory and presents the start address of each one. A descriptor is an 8-byte header followed by its payload. The header's total-size field is a 10-bit byte count held in bits [9:0] of the header's second 32-bit word. The walker fetches that word for every descriptor through a read port that has one cycle of latency.

The walker has two layout modes. In fixed-block mode the region is cut into equal slots. Each slot is the programmed block size plus 8 header bytes, and at most 32 slots are used. Any tail of the region too short for a whole slot is never addressed. In chained mode the descriptors sit back to back. Each following header begins after the current header plus the current payload, with the payload rounded up to a multiple of 4 bytes.

A start strobe latches the configuration and opens a walk. Each descriptor's header address is then shown for one valid cycle together with its zero-based index. A next strobe moves the walk to the following descriptor. The walk ends with a done flag. In chained mode an overflow flag reports a payload that runs past the end of the region.

Top module: `tdw_walker`

## Requirements
- R1: While reset is high and after it, until the first start, hdr_valid, hdr_err, mem_rd_en, done and overflow are all 0.
- R2: In fixed-block mode (cfg_var=0), descriptor k is shown with hdr_addr = cfg_base + k*(cfg_blk+8) and hdr_idx = k.
- R3: In fixed-block mode, blk_count equals floor(cfg_len/(cfg_blk+8)) clamped to 32 whenever a descriptor is shown.
- R4: In fixed-block mode, exactly blk_count descriptors are shown. The next strobe after the last one raises done, so the unused tail is never addressed.
- R5: hdr_err is 1 during a valid cycle exactly when the mode is fixed-block and the size field (bits [9:0] of the word at header+4) exceeds cfg_blk. It is 0 in chained mode.
- R6: In chained mode (cfg_var=1), the header after the one at address A with size S is at A + 8 + S rounded up to a multiple of 4. The first header is at cfg_base.
- R7: In chained mode, a next strobe whose following header would start at or beyond cfg_base+cfg_len ends the walk with done instead of showing it.
- R8: In chained mode, overflow rises in the valid cycle of a descriptor with A+8+S > cfg_base+cfg_len. It stays high until the next start, and the next strobe after that descriptor ends the walk with done.
- R9: For every descriptor, the walker asserts mem_rd_en for one cycle with mem_rd_addr = header address + 4. The data returned on the following cycle supplies the size field.
- R10: hdr_valid lasts exactly one cycle per descriptor. A next strobe given while the walker is not waiting after a shown descriptor has no effect.
- R11: A start given in the same cycle as next takes priority and restarts the walk at index 0 with the new configuration.
- R12: A walk with no room for any descriptor raises done without showing a descriptor. This is cfg_len = 0 in chained mode, or blk_count = 0 in fixed-block mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | AW | Byte address of the region start |
| cfg_len | input | AW | Region size in bytes |
| cfg_blk | input | 10 | Payload block size in bytes for fixed-block mode |
| cfg_var | input | 1 | 1 selects chained mode, 0 fixed-block mode |
| start | input | 1 | Latch configuration and begin a walk |
| next | input | 1 | Advance to the following descriptor |
| mem_rd_en | output | 1 | Header word read request |
| mem_rd_addr | output | AW | Byte address of the header word being read |
| mem_rd_data | input | 32 | Read data, valid one cycle after the request |
| hdr_valid | output | 1 | A descriptor is being shown this cycle |
| hdr_addr | output | AW | Header byte address of the shown descriptor |
| hdr_idx | output | AW-2 | Zero-based index of the shown descriptor |
| hdr_err | output | 1 | Shown payload exceeds the block size in fixed-block mode |
| blk_count | output | 6 | Number of usable fixed blocks |
| done | output | 1 | The walk has ended |
| overflow | output | 1 | A chained payload ran past the region end |

## Verification
Two events can land in the same cycle. The first is start and next together while the walker waits after a shown descriptor. The bench provokes this by aborting a fixed-block walk after its first descriptor and starting a chained walk with both strobes high. It then judges that index 0 appears at the new base. The second is an overflowing descriptor that is also the last of its chain. A directed chain places a payload across the region end, and the bench checks that overflow rises with that descriptor's valid cycle and that the following next gives done with overflow still set. Random walks in both modes, with odd and even block sizes and region sizes that hit the 32-block clamp, are compared against a bench model of the address sequence.

// File: rtl/tdw_pkg.sv
package tdw_pkg;

    localparam int HDR_BYTES    = 8;   // header length in bytes, both modes
    localparam int TSIZE_W      = 10;  // width of the header size field
    localparam int TSIZE_OFFSET = 4;   // byte offset of the word carrying the size field

    typedef logic [TSIZE_W-1:0] tsize_t;
    typedef logic [TSIZE_W:0]   tspan_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_READ,
        ST_WAIT,
        ST_SHOW,
        ST_HOLD
    } walk_st_e;

    typedef struct packed {
        logic last;
        logic ovf;
        logic err;
    } step_flags_t;

    // payload length rounded up to a 4-byte multiple
    function automatic tspan_t pad_dword(tsize_t n);
        tspan_t w;
        w = {1'b0, n} + tspan_t'(3);
        return w & ~tspan_t'(3);
    endfunction

    // fixed-mode slot pitch: payload block plus header
    function automatic tspan_t fixed_stride(tsize_t blk);
        return {1'b0, blk} + tspan_t'(HDR_BYTES);
    endfunction

endpackage

// File: rtl/tdw_blk_counter.sv
module tdw_blk_counter
    import tdw_pkg::*;
#(
    parameter int AW         = 16,
    parameter int MAX_BLOCKS = 32,
    parameter int CW         = $clog2(MAX_BLOCKS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] len_i,
    input  tspan_t        stride_i,
    output logic [CW-1:0] count_o,
    output logic          busy_o
);

    logic [AW-1:0] rem_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic [AW-1:0] stride_w;

    assign stride_w = AW'(stride_i);

    // repeated subtraction, one slot per cycle, stops at the clamp
    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (load) begin
            rem_q  <= len_i;
            cnt_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (cnt_q < CW'(MAX_BLOCKS) && rem_q >= stride_w) begin
                rem_q <= rem_q - stride_w;
                cnt_q <= cnt_q + 1'b1;
            end else begin
                busy_q <= 1'b0;
            end
        end
    end

    assign count_o = cnt_q;
    assign busy_o  = busy_q;

endmodule

// File: rtl/tdw_step.sv
module tdw_step
    import tdw_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CW    = 6,
    parameter int IDX_W = 14
) (
    input  logic [AW:0]      cur_i,
    input  logic [AW:0]      end_i,
    input  tsize_t           size_i,
    input  tsize_t           blk_i,
    input  logic             var_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [CW-1:0]    count_i,
    output logic [AW:0]      nxt_o,
    output step_flags_t      flags_o
);

    localparam int XW = AW + 1;

    logic [XW-1:0]  pay_end;
    logic [IDX_W:0] idx_inc;
    logic [IDX_W:0] cnt_ext;

    always_comb begin
        pay_end = cur_i + XW'(HDR_BYTES) + XW'(size_i);
        if (var_i) begin
            nxt_o = cur_i + XW'(HDR_BYTES) + XW'(pad_dword(size_i));
        end else begin
            nxt_o = cur_i + XW'(fixed_stride(blk_i));
        end
        idx_inc = {1'b0, idx_i} + 1'b1;
        cnt_ext = (IDX_W + 1)'(count_i);

        flags_o.ovf = var_i && (pay_end > end_i);
        flags_o.err = !var_i && (size_i > blk_i);
        if (var_i) begin
            flags_o.last = flags_o.ovf || (nxt_o >= end_i);
        end else begin
            flags_o.last = idx_inc >= cnt_ext;
        end
    end

endmodule

// File: rtl/tdw_walker.sv
module tdw_walker
    import tdw_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int MAX_BLOCKS = 32,
    localparam int CW        = $clog2(MAX_BLOCKS + 1),
    localparam int IDX_W     = AW - 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    cfg_base,
    input  logic [AW-1:0]    cfg_len,
    input  logic [TSIZE_W-1:0] cfg_blk,
    input  logic             cfg_var,
    input  logic             start,
    input  logic             next,
    output logic             mem_rd_en,
    output logic [AW-1:0]    mem_rd_addr,
    input  logic [DW-1:0]    mem_rd_data,
    output logic             hdr_valid,
    output logic [AW-1:0]    hdr_addr,
    output logic [IDX_W-1:0] hdr_idx,
    output logic             hdr_err,
    output logic [CW-1:0]    blk_count,
    output logic             done,
    output logic             overflow
);

    walk_st_e         state_q;
    logic [AW:0]      cur_q;
    logic [AW:0]      end_q;
    tsize_t           blk_q;
    tsize_t           size_q;
    logic             var_q;
    logic [IDX_W-1:0] idx_q;
    logic             ovf_q;
    logic             done_q;

    logic [CW-1:0]    cnt_w;
    logic             cnt_busy;
    logic [AW:0]      nxt_w;
    step_flags_t      flags_w;
    logic             unused_hi;

    assign unused_hi = ^mem_rd_data[DW-1:TSIZE_W];

    tdw_blk_counter #(
        .AW         (AW),
        .MAX_BLOCKS (MAX_BLOCKS),
        .CW         (CW)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (start && !cfg_var),
        .len_i    (cfg_len),
        .stride_i (fixed_stride(blk_q)),
        .count_o  (cnt_w),
        .busy_o   (cnt_busy)
    );

    tdw_step #(
        .AW    (AW),
        .CW    (CW),
        .IDX_W (IDX_W)
    ) u_step (
        .cur_i   (cur_q),
        .end_i   (end_q),
        .size_i  (size_q),
        .blk_i   (blk_q),
        .var_i   (var_q),
        .idx_i   (idx_q),
        .count_i (cnt_w),
        .nxt_o   (nxt_w),
        .flags_o (flags_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            end_q   <= '0;
            blk_q   <= '0;
            size_q  <= '0;
            var_q   <= 1'b0;
            idx_q   <= '0;
            ovf_q   <= 1'b0;
            done_q  <= 1'b0;
        end else if (start) begin
            // start outranks next and any walk in progress
            cur_q  <= {1'b0, cfg_base};
            end_q  <= {1'b0, cfg_base} + {1'b0, cfg_len};
            blk_q  <= cfg_blk;
            var_q  <= cfg_var;
            idx_q  <= '0;
            ovf_q  <= 1'b0;
            done_q <= 1'b0;
            if (!cfg_var) begin
                state_q <= ST_COUNT;
            end else if (cfg_len == '0) begin
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
            end else begin
                state_q <= ST_READ;
            end
        end else begin
            case (state_q)
                ST_COUNT: begin
                    if (!cnt_busy) begin
                        if (cnt_w == '0) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_READ;
                        end
                    end
                end
                ST_READ: state_q <= ST_WAIT;
                ST_WAIT: begin
                    size_q  <= mem_rd_data[TSIZE_W-1:0];
                    state_q <= ST_SHOW;
                end
                ST_SHOW: begin
                    if (flags_w.ovf) ovf_q <= 1'b1;
                    state_q <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (next) begin
                        if (flags_w.last) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            cur_q   <= nxt_w;
                            idx_q   <= idx_q + 1'b1;
                            state_q <= ST_READ;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_rd_en   = (state_q == ST_READ);
    assign mem_rd_addr = cur_q[AW-1:0] + AW'(TSIZE_OFFSET);
    assign hdr_valid   = (state_q == ST_SHOW);
    assign hdr_addr    = cur_q[AW-1:0];
    assign hdr_idx     = idx_q;
    assign hdr_err     = hdr_valid && flags_w.err;
    assign blk_count   = cnt_w;
    assign done        = done_q;
    assign overflow    = ovf_q || (hdr_valid && flags_w.ovf);

endmodule

// File: rtl/tdw_walker_chk.sv
module tdw_walker_chk #(
    parameter int IDX_W = 14,
    parameter int CW    = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             hdr_valid,
    input logic             hdr_err,
    input logic             overflow,
    input logic             done,
    input logic             mem_rd_en,
    input logic [IDX_W-1:0] hdr_idx,
    input logic [CW-1:0]    blk_count,
    input logic             var_q
);

    // R10: each descriptor is shown for a single cycle
    a_r10_one_cycle: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |=> !hdr_valid);

    // R9: a header read is one cycle wide and the data cycle shows nothing yet
    a_r9_read_gap: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && !start) |=> (!mem_rd_en && !hdr_valid));

    // R5: size error only accompanies a shown fixed-block descriptor
    a_r5_err_fixed: assert property (@(posedge clk) disable iff (rst)
        hdr_err |-> (hdr_valid && !var_q));

    // R8: overflow holds until a new start
    a_r8_ovf_hold: assert property (@(posedge clk) disable iff (rst)
        (overflow && !start) |=> overflow);

    // R8: overflow belongs to chained mode only
    a_r8_ovf_chain: assert property (@(posedge clk) disable iff (rst)
        overflow |-> var_q);

    // R7: an ended walk neither shows nor reads
    a_r7_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> (!hdr_valid && !mem_rd_en));

    // R4: fixed-block index stays below the slot count
    a_r4_idx_range: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && !var_q) |-> (hdr_idx < IDX_W'(blk_count)));

endmodule

bind tdw_walker tdw_walker_chk #(
    .IDX_W (IDX_W),
    .CW    (CW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .hdr_valid (hdr_valid),
    .hdr_err   (hdr_err),
    .overflow  (overflow),
    .done      (done),
    .mem_rd_en (mem_rd_en),
    .hdr_idx   (hdr_idx),
    .blk_count (blk_count),
    .var_q     (var_q)
);

// File: tb/tdw_walker_tb.sv
`timescale 1ns/1ps
module tdw_walker_tb;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] cfg_base = '0;
    logic [AW-1:0] cfg_len = '0;
    logic [9:0]    cfg_blk = '0;
    logic          cfg_var = 1'b0;
    logic          start = 1'b0;
    logic          next = 1'b0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [31:0]   mem_rd_data;
    logic          hdr_valid;
    logic [AW-1:0] hdr_addr;
    logic [AW-3:0] hdr_idx;
    logic          hdr_err;
    logic [5:0]    blk_count;
    logic          done;
    logic          overflow;

    logic [31:0] mem [0:1023];

    int vecs = 0;
    int errs = 0;
    int cyc  = 0;
    int exp_rd = 0;

    always #10 clk = ~clk;

    tdw_walker u_dut (
        .clk (clk), .rst (rst),
        .cfg_base (cfg_base), .cfg_len (cfg_len), .cfg_blk (cfg_blk), .cfg_var (cfg_var),
        .start (start), .next (next),
        .mem_rd_en (mem_rd_en), .mem_rd_addr (mem_rd_addr), .mem_rd_data (mem_rd_data),
        .hdr_valid (hdr_valid), .hdr_addr (hdr_addr), .hdr_idx (hdr_idx), .hdr_err (hdr_err),
        .blk_count (blk_count), .done (done), .overflow (overflow)
    );

    // one-cycle-latency memory model
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[11:2]];
    end

    task automatic chk(string req, int act, int exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // R9: every header read targets header address + 4
    always @(negedge clk) begin
        if (!rst && mem_rd_en) chk("R9 read address", int'(mem_rd_addr), exp_rd);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errs++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    function automatic int size_at(int a);
        logic [31:0] w;
        w = mem[((a + 4) >> 2) & 1023];
        return int'(w[9:0]);
    endfunction

    function automatic int exp_count(int l, int k);
        int c;
        c = l / (k + 8);
        return (c > 32) ? 32 : c;
    endfunction

    // one walk; max_show > 0 abandons it after that many descriptors
    task automatic run_walk(string tag, int b, int l, int k, bit v,
                            bit with_next, bit stray, int max_show);
        int  endp, cur, idx, cnt, sz, t, shown;
        bit  stop, ovf, first;
        @(negedge clk);
        cfg_base = AW'(b); cfg_len = AW'(l); cfg_blk = 10'(k); cfg_var = v;
        start = 1'b1; next = with_next; exp_rd = b + 4;
        @(negedge clk);
        start = 1'b0; next = stray;
        endp = b + l; cur = b; idx = 0; cnt = exp_count(l, k);
        stop = v ? (l == 0) : (cnt == 0);
        ovf = 1'b0; shown = 0; first = 1'b1;
        forever begin
            t = 0;
            do begin
                @(negedge clk);
                next = 1'b0;
                t++;
            end while (!hdr_valid && !done && t < 300);
            if (stop) begin
                chk({tag, first ? " R12 done" : (v ? " R7 done" : " R4 done")}, int'(done), 1);
                chk({tag, " R4 no descriptor after end"}, int'(hdr_valid), 0);
                chk({tag, " R8 overflow at end"}, int'(overflow), int'(ovf));
                return;
            end
            first = 1'b0;
            chk({tag, " R10 descriptor shown"}, int'(hdr_valid), 1);
            sz = size_at(cur);
            chk({tag, v ? " R6 address" : " R2 address"}, int'(hdr_addr), cur & 16'hFFFF);
            chk({tag, v ? " R6 index" : " R2 index"}, int'(hdr_idx), idx);
            if (!v) chk({tag, " R3 block count"}, int'(blk_count), cnt);
            chk({tag, " R5 size error"}, int'(hdr_err), int'(!v && sz > k));
            if (v && (cur + 8 + sz > endp)) ovf = 1'b1;
            chk({tag, " R8 overflow"}, int'(overflow), int'(ovf));
            shown++;
            if (max_show > 0 && shown == max_show) return;
            if (v) begin
                cur = cur + 8 + ((sz + 3) & ~3);
                stop = ovf || (cur >= endp);
            end else begin
                cur = cur + k + 8;
                stop = (idx + 1 >= cnt);
            end
            idx++;
            exp_rd = cur + 4;
            @(negedge clk);
            chk({tag, " R10 single valid cycle"}, int'(hdr_valid), 0);
            next = 1'b1;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) mem[i] = $urandom() & 32'hFFFF_FC3F;

        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 hdr_valid", int'(hdr_valid), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 overflow", int'(overflow), 0);
        chk("R1 mem_rd_en", int'(mem_rd_en), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", int'(hdr_valid | done | hdr_err | mem_rd_en | overflow), 0);

        // R4: 256-byte region, 64-byte blocks: 3 slots, 40-byte tail unused
        run_walk("fixed-tail", 0, 256, 64, 1'b0, 1'b0, 1'b0, 0);
        // R12: region shorter than one slot
        run_walk("fixed-empty", 40, 5, 64, 1'b0, 1'b0, 1'b0, 0);
        // R3: clamp at 32 slots
        run_walk("fixed-clamp", 8, 1000, 0, 1'b0, 1'b0, 1'b0, 0);
        // R5: oversize payload in first slot
        mem[501] = (mem[501] & 32'hFFFF_FC00) | 32'd100;
        run_walk("fixed-err", 2000, 200, 64, 1'b0, 1'b0, 1'b0, 0);

        // R8 with R7: chain whose fourth payload crosses the region end
        mem[26] = (mem[26] & 32'hFFFF_FC00) | 32'd5;
        mem[30] = (mem[30] & 32'hFFFF_FC00) | 32'd20;
        mem[37] = (mem[37] & 32'hFFFF_FC00) | 32'd3;
        mem[40] = (mem[40] & 32'hFFFF_FC00) | 32'd10;
        run_walk("chain-ovf", 100, 60, 0, 1'b1, 1'b0, 1'b0, 0);
        // R12: empty chained region
        run_walk("chain-empty", 300, 0, 0, 1'b1, 1'b0, 1'b0, 0);

        // R10: next during the header fetch is ignored
        run_walk("R10 stray next", 400, 300, 12, 1'b0, 1'b0, 1'b1, 0);
        run_walk("R10 stray next chain", 400, 120, 0, 1'b1, 1'b0, 1'b1, 0);

        // R11: start and next together restart at index 0
        run_walk("R11 abort", 600, 400, 32, 1'b0, 1'b0, 1'b0, 1);
        run_walk("R11 restart", 700, 200, 0, 1'b1, 1'b1, 1'b0, 0);

        for (int n = 0; n < 40; n++) begin
            int  b, l, k;
            bit  v;
            v = 1'(($urandom() >> 3) & 1);
            b = $urandom_range(0, 1000);
            l = $urandom_range(0, 1500);
            k = ((n % 3) == 0) ? $urandom_range(0, 100) : 4 * $urandom_range(0, 24);
            run_walk(v ? "rand-chain" : "rand-fixed", b, l, k, v, 1'b0, 1'b0, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule